// File: doc/BRIEF.md
# Counting-Ramp ADC Controller

This block holds the digital half of a ramp-type analog-to-digital converter. A start strobe clears an up-counter. The counter then climbs by one code per clock, and its value drives the code input of an external DAC, with each bit going to the DAC bit of the same weight. An analog comparator reports when the DAC output is above the sampled input. The first time that comparator bit is seen high during a conversion, the counter stops. Its value is copied into a result register and a one-clock done pulse is issued.

Conversion time depends on the input level, because small inputs trip the comparator after only a few codes. If the counter reaches its top code without the comparator tripping, the input is out of range. In that case the block saturates the result to all ones, raises an over-range flag and releases busy. The result and the flag keep their values until the next conversion finishes.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After reset, busy, done and the over-range flag are low, and both the DAC code and the result are all zeros.
- R2: A start strobe sampled high while idle sets busy on the following cycle, with the DAC code cleared to zero.
- R3: While busy and the comparator bit is low below the top code, the DAC code rises by exactly one on each clock.
- R4: When the comparator bit is sampled high while busy, the current DAC code becomes the result, busy falls, done pulses and the over-range flag is cleared.
- R5: With the comparator tripping on code c, done is seen c+1 clocks after the start strobe is accepted, so lower inputs finish sooner.
- R6: If the top code (all ones, 15 at the default 4-bit width) is sampled with the comparator bit still low, the result becomes all ones, the over-range flag is set, and done pulses with busy falling. This happens 2^WIDTH clocks after start.
- R7: The result and the over-range flag change only together with a done pulse, and keep their last value through the next conversion.
- R8: A start strobe sampled while busy is ignored: the conversion in progress keeps its count, timing and result.
- R9: Done is high for exactly one clock per completed conversion.
- R10: While idle, the DAC code stays frozen at the value it had when the conversion ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-of-conversion strobe |
| cmp_i | input | 1 | Comparator bit, high when the DAC output exceeds the input |
| dac_code_o | output | WIDTH | Code to the external DAC |
| result_o | output | WIDTH | Held conversion result |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-clock pulse when the result updates |
| overrange_o | output | 1 | Last conversion ran past full scale |

## Verification
The hardest case to reach from the ports is a strobe arriving in the middle of a ramp, followed by a check that it neither restarts the count nor shifts the finish time. The bench models the comparator as the DAC code compared against a target level. It pulses start several codes into a long ramp and then requires the exact completion latency and result of an undisturbed conversion. The over-range path is reached with a target at or above full scale, which keeps the comparator low through the top code.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RAMP = 1'b1
  } ramp_state_e;
endpackage

// File: rtl/ramp_counter.sv
module ramp_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] code_o,
  output logic             full_o
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  function automatic logic [WIDTH-1:0] step_up(input logic [WIDTH-1:0] c);
    return c + 1'b1;
  endfunction

  logic [WIDTH-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     code_q <= '0;
    else if (clr_i) code_q <= '0;
    else if (inc_i) code_q <= step_up(code_q);
  end

  assign code_o = code_q;
  assign full_o = (code_q == TOP);

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (code_o == '0));
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i) |=> (code_o == $past(code_o) + 1'b1));
  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !clr_i) |=> $stable(code_o));
endmodule

// File: rtl/ramp_seq.sv
module ramp_seq
  import ramp_adc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cmp_i,
  input  logic full_i,
  output logic busy_o,
  output logic clr_o,
  output logic inc_o,
  output logic trip_o,
  output logic ovf_o
);
  ramp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    clr_o   = 1'b0;
    inc_o   = 1'b0;
    trip_o  = 1'b0;
    ovf_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        clr_o   = 1'b1;
        state_d = ST_RAMP;
      end
      ST_RAMP: begin
        if (cmp_i) begin
          trip_o  = 1'b1;
          state_d = ST_IDLE;
        end else if (full_i) begin
          ovf_o   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          inc_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy_o = (state_q == ST_RAMP);

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);
  assert_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |=> !busy_o);
  assert_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> !busy_o);
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |-> !clr_o);
  assert_events_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_o, inc_o, trip_o, ovf_o}));
endmodule

// File: rtl/ramp_result.sv
module ramp_result #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trip_i,
  input  logic             ovf_i,
  input  logic [WIDTH-1:0] code_i,
  output logic [WIDTH-1:0] result_o,
  output logic             overrange_o,
  output logic             done_o
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  function automatic logic [WIDTH-1:0] pick_result(input logic ovf,
                                                   input logic [WIDTH-1:0] c);
    return ovf ? TOP : c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o    <= '0;
      overrange_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= trip_i | ovf_i;
      if (trip_i | ovf_i) begin
        result_o    <= pick_result(ovf_i, code_i);
        overrange_o <= ovf_i;
      end
    end
  end

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trip_i |=> (result_o == $past(code_i) && !overrange_o));
  assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |=> (result_o == TOP && overrange_o));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(result_o) && $stable(overrange_o)) |-> done_o);
  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             overrange_o
);
  logic clr_w, inc_w, trip_w, ovf_w, full_w;

  ramp_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .cmp_i  (cmp_i),
    .full_i (full_w),
    .busy_o (busy_o),
    .clr_o  (clr_w),
    .inc_o  (inc_w),
    .trip_o (trip_w),
    .ovf_o  (ovf_w)
  );

  ramp_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr_w),
    .inc_i (inc_w),
    .code_o(dac_code_o),
    .full_o(full_w)
  );

  ramp_result #(.WIDTH(WIDTH)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_i     (trip_w),
    .ovf_i      (ovf_w),
    .code_i     (dac_code_o),
    .result_o   (result_o),
    .overrange_o(overrange_o),
    .done_o     (done_o)
  );

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: tb/ramp_adc_ctrl_tb_top.sv
module ramp_adc_ctrl_tb_top;
  localparam int W   = 4;
  localparam int TOP = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp;
  logic [W-1:0] code, result;
  logic busy, done, ovr;
  int target = 100;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // Behavioural DAC + comparator: high when DAC output exceeds the input level.
  always_comb cmp = (int'(code) > target);

  ramp_adc_ctrl #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp),
    .dac_code_o(code), .result_o(result), .busy_o(busy),
    .done_o(done), .overrange_o(ovr)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One conversion; optional stray start at ramp step stray_at (0 = none).
  task automatic convert(input int lvl, input int stray_at);
    int exp_res, exp_lat, lat, prev_res, prev_ovr;
    bit exp_ovr;
    exp_ovr  = (lvl >= TOP);
    exp_res  = exp_ovr ? TOP : ((lvl < 0) ? 0 : lvl + 1);
    exp_lat  = exp_res + 1;
    prev_res = result;
    prev_ovr = ovr;
    target   = lvl;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy", busy, 1);
    check("R2 code", code, 0);
    lat = 1;
    while (!done && lat < 40) begin
      check("R7 result held", result, prev_res);
      check("R7 ovr held", ovr, prev_ovr);
      start = (lat == stray_at);
      @(negedge clk);
      start = 1'b0;
      if (!done) check("R3 code step", code, lat);
      lat++;
    end
    lat--;
    check("R5 latency", lat, exp_lat);
    check(exp_ovr ? "R6 result" : "R4 result", result, exp_res);
    check(exp_ovr ? "R6 ovr" : "R4 ovr", ovr, exp_ovr);
    check("R4 busy", busy, 0);
    @(negedge clk);
    check("R9 done", done, 0);
    check("R10 code", code, exp_res);
    check("R7 result", result, exp_res);
    repeat (3) @(negedge clk);
    check("R10 code hold", code, exp_res);
    check("R9 done idle", done, 0);
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 ovr", ovr, 0);
    check("R1 code", code, 0);
    check("R1 result", result, 0);
  endtask

  task automatic t_levels();
    convert(5, 0);
    convert(0, 0);
    convert(-1, 0);   // comparator already high at code 0
    convert(13, 0);
  endtask

  task automatic t_overrange();
    convert(15, 0);   // R6 at full scale
    convert(40, 0);   // R6 well above
    convert(2, 0);    // R4 flag clears
  endtask

  task automatic t_stray_start();
    convert(10, 4);   // R8 start mid ramp ignored
    convert(20, 9);   // R8 during over-range ramp
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_levels();
    t_overrange();
    t_stray_start();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule